// File: doc/BRIEF.md
# Flash Status and Self-Timed Operation Tracker

This block keeps the status state of a serial flash device: the ready/busy flag, the write-enable latch, the program/erase error flag, the reset-enable bit and the lockdown-enable bit. When the command decoder accepts a program or erase, the block raises busy for a number of clock cycles that depends on the operation type. At the end it records whether verification failed and clears the write-enable latch.

The block also carries out the confirmed software reset. A reset is carried out only when reset is enabled, the confirmation byte is right and chip select rose on a byte boundary. A reset aborts any operation in progress and holds busy for its own recovery time.

Both status bytes are driven continuously from registered state. A serializer that shifts them out again and again while chip select stays low therefore always sends the latest busy value, so software can poll for completion. Array storage and serial framing belong to neighbouring blocks.

Top module: `flash_status_tracker`

## Requirements
- R1: After reset both status bytes read 00h.
- R2: When idle, `cmd_wren` sets the write-enable latch (status byte 1 bit 1) and `cmd_wrdi` clears it.
- R3: An operation start is accepted when the block is idle, the latch is 1, `op_refused` is 0 and the kind code is valid. Busy (bit 0 of both bytes) then reads 1 for exactly the kind's cycle count: 0 page program 8, 1 4 KB erase 12, 2 32 KB erase 16, 3 64 KB erase 20, 4 chip erase 24.
- R4: When an accepted operation completes, the latch clears. The error flag (status byte 1 bit 5) becomes 1 if `verify_fail` was high in any busy cycle of that operation, and 0 otherwise.
- R5: A start that is refused (`op_refused` high, latch 0, or kind code 5 to 7) never raises busy and leaves the error flag unchanged. A refused start made while the latch is 1 clears the latch.
- R6: While busy, operation starts, `cmd_wren`, `cmd_wrdi` and status byte 2 writes have no effect.
- R7: A status byte 2 write made when idle with the latch at 1 loads reset-enable from data bit 4 and lockdown-enable from data bit 3, which read back at status byte 2 bits 4 and 3, and clears the latch. With the latch at 0 the write changes nothing.
- R8: A reset request is honoured only if reset-enable is 1, the confirmation byte is D0h and `rst_aligned` is 1. Otherwise it changes no status bit.
- R9: An honoured reset aborts any running operation, clears the latch and holds busy for 6 cycles. It leaves the error flag, reset-enable and lockdown-enable unchanged.
- R10: If an honoured reset falls in the last busy cycle of an operation, the reset wins: the operation's error result is discarded and busy continues for the reset time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Program/erase start strobe |
| op_kind | input | 3 | Operation kind code |
| op_refused | input | 1 | Start refused by protection, lockdown or abort |
| verify_fail | input | 1 | Verification failure seen during the operation |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| sr2_wr | input | 1 | Status byte 2 write strobe |
| sr2_din | input | 8 | Status byte 2 write data |
| rst_cmd | input | 1 | Reset request strobe, given at chip-select rise |
| rst_confirm | input | 8 | Confirmation byte received with the reset |
| rst_aligned | input | 1 | Chip select rose on a byte boundary |
| sr1 | output | 8 | Status byte 1: bit0 busy, bit1 latch, bit5 error |
| sr2 | output | 8 | Status byte 2: bit0 busy, bit3 lockdown-enable, bit4 reset-enable |

## Verification
The completion of an operation and an honoured reset can land on the same clock edge, and each of them wants to update busy, the latch and the error flag. The bench provokes this by running a page program with a verify failure injected, counting busy cycles from the bench side, and issuing the reset in the program's eighth and last busy cycle. The result is judged correct if busy stays high for the full reset time after that edge and the error flag keeps the value it had before the program, rather than taking the discarded failure.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    OP_PAGE = 3'd0,
    OP_E4K  = 3'd1,
    OP_E32K = 3'd2,
    OP_E64K = 3'd3,
    OP_CHIP = 3'd4
  } op_kind_t;

  // kind codes above the chip erase are not operations
  function automatic logic kind_valid(input logic [2:0] k);
    return k <= OP_CHIP;
  endfunction

  // busy duration of one operation kind, picked from the parameter set
  function automatic int unsigned kind_cycles(input logic [2:0] k,
                                              input int unsigned t_page,
                                              input int unsigned t_e4k,
                                              input int unsigned t_e32k,
                                              input int unsigned t_e64k,
                                              input int unsigned t_chip);
    case (k)
      OP_PAGE: return t_page;
      OP_E4K:  return t_e4k;
      OP_E32K: return t_e32k;
      OP_E64K: return t_e64k;
      default: return t_chip;
    endcase
  endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          last
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= load_val;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
  assign last = (remain == CW'(1));

  // R3: a nonzero load always yields busy on the next cycle
  a_r3_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load && (load_val != '0) |=> busy);

  // R3: busy ends only through its last cycle
  a_r3_end_via_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last));

endmodule

// File: rtl/flash_reset_gate.sv
module flash_reset_gate #(
  parameter logic [7:0] CONFIRM = 8'hD0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_cmd,
  input  logic [7:0] rst_confirm,
  input  logic       rst_aligned,
  input  logic       rste,
  output logic       take
);

  assign take = rst_cmd && rste && rst_aligned && (rst_confirm == CONFIRM);

  // R8: an honoured reset always had a request with the enable set
  a_r8_take_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (rst_cmd && rste));

endmodule

// File: rtl/flash_status_tracker.sv
module flash_status_tracker
  import flash_stat_pkg::*;
#(
  parameter int          CW      = 16,
  parameter int unsigned T_PAGE  = 8,
  parameter int unsigned T_E4K   = 12,
  parameter int unsigned T_E32K  = 16,
  parameter int unsigned T_E64K  = 20,
  parameter int unsigned T_CHIP  = 24,
  parameter int unsigned T_RST   = 6,
  parameter logic [7:0]  CONFIRM = 8'hD0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic [2:0] op_kind,
  input  logic       op_refused,
  input  logic       verify_fail,
  input  logic       cmd_wren,
  input  logic       cmd_wrdi,
  input  logic       sr2_wr,
  input  logic [7:0] sr2_din,
  input  logic       rst_cmd,
  input  logic [7:0] rst_confirm,
  input  logic       rst_aligned,
  output logic [7:0] sr1,
  output logic [7:0] sr2
);

  localparam int RSTE_BIT = 4;
  localparam int SLE_BIT  = 3;

  logic wel, epe, rste, sle, vf_seen, run_is_rst;
  logic busy, last, rst_take, op_go, op_reject, op_done, tmr_load;
  logic [CW-1:0] tmr_val;

  // internal events brought out as named wires
  assign op_go     = op_start && !busy && wel && !op_refused && kind_valid(op_kind);
  assign op_reject = op_start && !busy && !op_go;
  assign op_done   = busy && last && !run_is_rst && !rst_take;
  assign tmr_load  = rst_take || op_go;
  assign tmr_val   = rst_take ? CW'(T_RST)
                              : CW'(kind_cycles(op_kind, T_PAGE, T_E4K, T_E32K, T_E64K, T_CHIP));

  flash_reset_gate #(.CONFIRM(CONFIRM)) u_gate (
    .clk(clk), .rst_n(rst_n), .rst_cmd(rst_cmd), .rst_confirm(rst_confirm),
    .rst_aligned(rst_aligned), .rste(rste), .take(rst_take)
  );

  flash_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .busy(busy), .last(last)
  );

  // kind of the running timed activity and its verify result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_is_rst <= 1'b0;
      vf_seen    <= 1'b0;
    end else if (tmr_load) begin
      run_is_rst <= rst_take;
      vf_seen    <= 1'b0;
    end else if (busy && verify_fail) begin
      vf_seen    <= 1'b1;
    end
  end

  // error flag: written only at a real completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epe <= 1'b0;
    else if (op_done) epe <= vf_seen || verify_fail;
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wel <= 1'b0;
    else if (rst_take)          wel <= 1'b0;
    else if (busy)              wel <= op_done ? 1'b0 : wel;
    else if (op_reject && wel)  wel <= 1'b0;
    else if (op_go)             wel <= 1'b1;
    else if (sr2_wr || cmd_wrdi) wel <= 1'b0;
    else if (cmd_wren)          wel <= 1'b1;
  end

  // status byte 2 bits, written only when idle and enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rste <= 1'b0;
      sle  <= 1'b0;
    end else if (sr2_wr && !busy && !op_start && wel && !rst_take) begin
      rste <= sr2_din[RSTE_BIT];
      sle  <= sr2_din[SLE_BIT];
    end
  end

  always_comb begin
    sr1 = '0;
    sr1[0] = busy;
    sr1[1] = wel;
    sr1[5] = epe;
    sr2 = '0;
    sr2[0] = busy;
    sr2[SLE_BIT]  = sle;
    sr2[RSTE_BIT] = rste;
  end

  // R4: completion leaves the latch cleared
  a_r4_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !wel);

  // R5: a refused start without reset never starts a timed run
  a_r5_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject && !rst_take |=> !busy);

  // R5: error flag moves only on a completion
  a_r5_epe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> $stable(epe));

  // R6: latch is frozen mid-operation
  a_r6_busy_wel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last && !rst_take |=> $stable(wel));

  // R6: status byte 2 bits are frozen while busy
  a_r6_busy_sr2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rste) && $stable(sle));

  // R9: honoured reset makes busy and clears the latch
  a_r9_reset_effect: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> busy && !wel);

  // R10: reset never updates the error flag, even at a completion edge
  a_r10_reset_keeps_epe: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> $stable(epe));

endmodule

// File: tb/flash_status_tracker_bench.sv
module flash_status_tracker_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  CYC_RST = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_refused = 0, verify_fail = 0;
  logic [2:0] op_kind = '0;
  logic cmd_wren = 0, cmd_wrdi = 0, sr2_wr = 0, rst_cmd = 0, rst_aligned = 0;
  logic [7:0] sr2_din = '0, rst_confirm = '0;
  logic [7:0] sr1, sr2;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_tracker u_flash_status_tracker (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_refused(op_refused), .verify_fail(verify_fail), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .sr2_wr(sr2_wr), .sr2_din(sr2_din), .rst_cmd(rst_cmd),
    .rst_confirm(rst_confirm), .rst_aligned(rst_aligned), .sr1(sr1), .sr2(sr2)
  );

  function automatic int kind_len(input int k);
    return 8 + 4 * k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe_wren();
    @(negedge clk); cmd_wren = 1;
    @(negedge clk); cmd_wren = 0;
  endtask

  task automatic strobe_wrdi();
    @(negedge clk); cmd_wrdi = 1;
    @(negedge clk); cmd_wrdi = 0;
  endtask

  task automatic strobe_op(input int k, input logic refused);
    @(negedge clk); op_start = 1; op_kind = 3'(k); op_refused = refused;
    @(negedge clk); op_start = 0; op_refused = 0;
  endtask

  task automatic strobe_sr2(input logic [7:0] d);
    @(negedge clk); sr2_wr = 1; sr2_din = d;
    @(negedge clk); sr2_wr = 0;
  endtask

  task automatic strobe_rst(input logic [7:0] c, input logic al);
    @(negedge clk); rst_cmd = 1; rst_confirm = c; rst_aligned = al;
    @(negedge clk); rst_cmd = 0;
  endtask

  // counts remaining busy samples, ends on the first idle negedge
  task automatic busy_len(output int n);
    n = 0;
    while (sr1[0] && n < 500) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    check("R1 sr1", sr1, 8'h00);
    check("R1 sr2", sr2, 8'h00);
  endtask

  task automatic t_wel();
    strobe_wren();
    check("R2 wren", sr1[1], 1);
    strobe_wrdi();
    check("R2 wrdi", sr1[1], 0);
  endtask

  task automatic t_kinds();
    int n;
    for (int k = 0; k < 5; k++) begin
      strobe_wren();
      strobe_op(k, 0);
      check("R3 busy both bytes", {sr1[0], sr2[0]}, 2'b11);
      busy_len(n);
      check($sformatf("R3 kind %0d length", k), n, kind_len(k));
      check("R4 wel cleared", sr1[1], 0);
      check("R4 epe clean", sr1[5], 0);
    end
  endtask

  task automatic t_verify();
    int n;
    strobe_wren();
    strobe_op(2, 0);
    repeat (3) @(negedge clk);
    verify_fail = 1;
    @(negedge clk); verify_fail = 0;
    busy_len(n);
    check("R4 epe set on verify fail", sr1[5], 1);
  endtask

  task automatic t_refused();
    int n;
    strobe_wren();
    strobe_op(0, 1);
    check("R5 refused no busy", sr1[0], 0);
    check("R5 refused epe kept", sr1[5], 1);
    check("R5 refused clears wel", sr1[1], 0);
    strobe_op(1, 0);
    check("R5 no wel no busy", sr1[0], 0);
    strobe_wren();
    strobe_op(6, 0);
    check("R5 bad kind no busy", sr1[0], 0);
    check("R5 bad kind epe kept", sr1[5], 1);
    strobe_wren();
    strobe_op(0, 0);
    busy_len(n);
    check("R4 epe rewritten clean", sr1[5], 0);
  endtask

  task automatic t_rst_disabled();
    strobe_wren();
    strobe_rst(8'hD0, 1);
    check("R8 rste=0 no busy", sr1[0], 0);
    check("R8 rste=0 wel kept", sr1[1], 1);
    strobe_wrdi();
  endtask

  task automatic t_sr2();
    strobe_sr2(8'h18);
    check("R7 no wel no write", sr2, 8'h00);
    strobe_wren();
    strobe_sr2(8'h18);
    check("R7 rste/sle loaded", sr2, 8'h18);
    check("R7 wel cleared", sr1[1], 0);
  endtask

  task automatic t_busy_ignore();
    int n;
    strobe_wren();
    strobe_op(1, 0);
    @(negedge clk);
    op_start = 1; op_kind = 3'd4; cmd_wrdi = 1; sr2_wr = 1; sr2_din = 8'h00;
    @(negedge clk);
    op_start = 0; cmd_wrdi = 0; sr2_wr = 0;
    check("R6 wel held while busy", sr1[1], 1);
    check("R6 sr2 write ignored", sr2[4:3], 2'b11);
    busy_len(n);
    check("R6 start ignored length", n, kind_len(1) - 2);
  endtask

  task automatic t_rst_reject();
    strobe_wren();
    strobe_rst(8'hA5, 1);
    check("R8 bad confirm", {sr1[1], sr1[0]}, 2'b10);
    strobe_rst(8'hD0, 0);
    check("R8 misaligned", {sr1[1], sr1[0]}, 2'b10);
    strobe_wrdi();
  endtask

  task automatic t_rst_ok();
    int n;
    strobe_wren();
    strobe_op(0, 0);
    @(negedge clk);
    strobe_rst(8'hD0, 1);
    check("R9 wel cleared", sr1[1], 0);
    busy_len(n);
    check("R9 reset length", n, CYC_RST);
    check("R9 epe kept", sr1[5], 0);
    check("R9 rste/sle kept", sr2[4:3], 2'b11);
  endtask

  task automatic t_collision();
    int n;
    strobe_wren();
    strobe_op(0, 0);
    verify_fail = 1;
    @(negedge clk); verify_fail = 0;
    repeat (kind_len(0) - 2) @(negedge clk);
    check("R10 still busy at last cycle", sr1[0], 1);
    rst_cmd = 1; rst_confirm = 8'hD0; rst_aligned = 1;
    @(negedge clk); rst_cmd = 0;
    busy_len(n);
    check("R10 reset length after collision", n, CYC_RST);
    check("R10 epe not updated", sr1[5], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_wel();
    t_kinds();
    t_verify();
    t_refused();
    t_rst_disabled();
    t_sr2();
    t_busy_ignore();
    t_rst_reject();
    t_rst_ok();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule